// File: doc/BRIEF.md
# Table-Mapped Programmable Clock Divider

This block turns a fast source clock into a slower rate, expressed as a single-cycle enable pulse and a 50% duty square wave. Both outputs stay in the source clock domain. A narrow select field picks the division ratio. The ratio is not the select code plus one. It comes from a small table, and parameters choose which table is built.

There are two silicon generations. Each has a general table and a table for MAC bus clocks. In the first generation the ratio is twice the code plus one. In the second generation it is four times the code plus one. The second generation's MAC table repeats divide-by-4 for the two lowest codes and then follows the first-generation series. A narrower 2-bit select port reaches only the first four entries of a table.

The select field is sampled only when a full output period ends. This lets software reprogram the ratio at any moment without producing a shortened or stretched period. Consumers use `tick_o` as a clock enable and `div_clk_o` where a waveform is needed.

Top module: `tbl_clk_div`

## Requirements
- R1: With `GEN_B=0` and `MAC_TBL=0`, select code c (0..7) gives a period of 2*(c+1) source cycles: 2, 4, 6, 8, 10, 12, 14, 16.
- R2: With `GEN_B=1` and `MAC_TBL=0`, select code c gives a period of 4*(c+1) source cycles: 4, 8, 12, 16, 20, 24, 28, 32.
- R3: With `GEN_B=1` and `MAC_TBL=1`, codes 0 and 1 both give a period of 4, and codes 2..7 give 6, 8, 10, 12, 14, 16.
- R4: With `GEN_B=0` and `MAC_TBL=1`, the ratios are identical to R1.
- R5: With `SEL_W=2`, the 2-bit code c (0..3) selects table entry c of the chosen table, so second-generation codes 0..3 give 4, 8, 12, 16.
- R6: `tick_o` is high for exactly one source cycle per output period, and never on two consecutive cycles.
- R7: `div_clk_o` is high for exactly ratio/2 cycles of each period. It is high during the cycle in which `tick_o` is high, and it falls on the edge that ends that cycle.
- R8: The select value is taken only at the edge that ends a period. A change in the middle of a period leaves that period's length unchanged, and the following period uses the new ratio.
- R9: While `rst_ni` is low, `tick_o` and `div_clk_o` are low. The first rising edge after release loads the ratio from `sel_i`, and the first `tick_o` appears in the ratio-th cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | SEL_W | Ratio select code, looked up in the parameter-chosen table |
| tick_o | output | 1 | One-cycle enable pulse, once per divided period |
| div_clk_o | output | 1 | 50% duty divided waveform, registered |

## Verification
The hardest situation to create from the ports is a select change that lands strictly inside a period. The change has to be timed against the divider's own phase rather than against reset. The stimulus first locks onto a `tick_o` pulse. It then counts three source cycles into the next period before it changes `sel_i`. It measures that period and the one after it separately, so a design that samples the select early produces a period of the wrong length. Reset applied mid-run, followed by release with a fresh code, covers the path that loads the first ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // ratio for one table entry; gen_b picks the generation, mac_tbl the bus-clock variant
  function automatic int unsigned div_ratio(bit gen_b, bit mac_tbl, int unsigned code);
    if (!gen_b)          return 2 * (code + 1);
    if (!mac_tbl)        return 4 * (code + 1);
    if (code < 2)        return 4;
    return 2 * (code + 1);
  endfunction

  function automatic int unsigned max_ratio(bit gen_b, bit mac_tbl, int unsigned sel_w);
    int unsigned m;
    m = 0;
    for (int unsigned c = 0; c < (1 << sel_w); c++)
      if (div_ratio(gen_b, mac_tbl, c) > m) m = div_ratio(gen_b, mac_tbl, c);
    return m;
  endfunction

endpackage

// File: rtl/ratio_lut.sv
module ratio_lut #(
  parameter bit GEN_B   = 1'b0,
  parameter bit MAC_TBL = 1'b0,
  parameter int SEL_W   = 3,
  parameter int RATIO_W = 6
) (
  input  logic [SEL_W-1:0]   code_i,
  output logic [RATIO_W-1:0] ratio_o
);

  logic [RATIO_W-1:0] code_p1;
  assign code_p1 = RATIO_W'(code_i) + RATIO_W'(1);

  generate
    if (!GEN_B) begin : g_gen_a
      // both general and bus tables: 2*(c+1)
      assign ratio_o = code_p1 << 1;
    end else if (!MAC_TBL) begin : g_gen_b
      assign ratio_o = code_p1 << 2;
    end else begin : g_gen_b_mac
      // codes 0 and 1 collapse onto divide-by-4
      assign ratio_o = (code_i < SEL_W'(2)) ? RATIO_W'(4) : (code_p1 << 1);
    end
  endgenerate

endmodule

// File: rtl/period_ctr.sv
module period_ctr #(
  parameter int RATIO_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_nxt_i,
  output logic               wrap_o,
  output logic               mid_o,
  output logic               run_o,
  output logic [RATIO_W-1:0] ratio_o
);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               run_q;

  assign wrap_o  = run_q && (cnt_q == ratio_q - RATIO_W'(1));
  assign mid_o   = run_q && (cnt_q == (ratio_q >> 1) - RATIO_W'(1));
  assign run_o   = run_q;
  assign ratio_o = ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      run_q   <= 1'b0;
    end else if (!run_q || wrap_o) begin
      // select is only sampled here: first edge after reset or period end
      run_q   <= 1'b1;
      ratio_q <= ratio_nxt_i;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + RATIO_W'(1);
    end
  end

endmodule

// File: rtl/wave_out.sv
module wave_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mid_i,
  input  logic wrap_i,
  output logic wave_o
);

  logic wave_q;
  assign wave_o = wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wave_q <= 1'b0;
    else if (mid_i)  wave_q <= 1'b1;
    else if (wrap_i) wave_q <= 1'b0;
  end

endmodule

// File: rtl/tbl_clk_div.sv
module tbl_clk_div
  import clkdiv_pkg::*;
#(
  parameter bit GEN_B   = 1'b0,
  parameter bit MAC_TBL = 1'b0,
  parameter int SEL_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o,
  output logic             div_clk_o
);

  localparam int unsigned MAX_R   = max_ratio(GEN_B, MAC_TBL, SEL_W);
  localparam int          RATIO_W = $clog2(MAX_R + 1);

  logic [RATIO_W-1:0] ratio_nxt;
  logic [RATIO_W-1:0] act_ratio;
  logic               wrap, mid, run;

  ratio_lut #(
    .GEN_B(GEN_B), .MAC_TBL(MAC_TBL), .SEL_W(SEL_W), .RATIO_W(RATIO_W)
  ) u_lut (
    .code_i (sel_i),
    .ratio_o(ratio_nxt)
  );

  period_ctr #(.RATIO_W(RATIO_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_nxt_i(ratio_nxt),
    .wrap_o     (wrap),
    .mid_o      (mid),
    .run_o      (run),
    .ratio_o    (act_ratio)
  );

  wave_out u_wave (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mid_i (mid),
    .wrap_i(wrap),
    .wave_o(div_clk_o)
  );

  assign tick_o = wrap;

endmodule

// File: rtl/tbl_clk_div_chk.sv
module tbl_clk_div_chk #(
  parameter int RATIO_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_o,
  input logic               div_clk_o,
  input logic               run,
  input logic [RATIO_W-1:0] act_ratio
);

  // R6: single-cycle pulse
  a_r6_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R7: waveform high in the tick cycle
  a_r7_high_at_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> div_clk_o);

  // R7: waveform only falls right after a tick
  a_r7_fall_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_clk_o) |-> $past(tick_o));

  // R8: active ratio held except across a period boundary
  a_r8_ratio_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run) && !$past(tick_o)) |-> $stable(act_ratio));

  // R1: loaded ratio is even and at least 2
  a_r1_ratio_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (act_ratio[0] == 1'b0 && act_ratio >= RATIO_W'(2)));

  // R9: no output activity before the first load
  a_r9_quiet_before_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!tick_o && !div_clk_o));

endmodule

bind tbl_clk_div tbl_clk_div_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_o   (tick_o),
  .div_clk_o(div_clk_o),
  .run      (run),
  .act_ratio(act_ratio)
);

// File: tb/tb_tbl_clk_div.sv
module tb_tbl_clk_div;

  localparam time TCK = 10ns;
  localparam int  ND  = 5;

  // code, gen A, gen B, gen B bus table
  localparam int VEC [8][4] = '{
    '{5, 12, 24, 12}, '{0, 2, 4, 4},  '{7, 16, 32, 16}, '{2, 6, 12, 6},
    '{1, 4, 8, 4},    '{6, 14, 28, 14}, '{3, 8, 16, 8}, '{4, 10, 20, 10}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [ND-1:0] tk, ck;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(TCK/2) clk = ~clk;

  tbl_clk_div #(.GEN_B(1'b0), .MAC_TBL(1'b0), .SEL_W(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .tick_o(tk[0]), .div_clk_o(ck[0]));
  tbl_clk_div #(.GEN_B(1'b0), .MAC_TBL(1'b1), .SEL_W(3)) dut_am (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .tick_o(tk[1]), .div_clk_o(ck[1]));
  tbl_clk_div #(.GEN_B(1'b1), .MAC_TBL(1'b0), .SEL_W(3)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .tick_o(tk[2]), .div_clk_o(ck[2]));
  tbl_clk_div #(.GEN_B(1'b1), .MAC_TBL(1'b1), .SEL_W(3)) dut_bm (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .tick_o(tk[3]), .div_clk_o(ck[3]));
  tbl_clk_div #(.GEN_B(1'b1), .MAC_TBL(1'b0), .SEL_W(2)) dut_b2 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel[1:0]), .tick_o(tk[4]), .div_clk_o(ck[4]));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sync to a tick, then measure the following period length and high count
  task automatic measure(input int idx, output int per, output int hi);
    do @(negedge clk); while (!tk[idx]);
    per = 0;
    hi  = 0;
    do begin
      @(negedge clk);
      per++;
      if (ck[idx]) hi++;
    end while (!tk[idx] && per < 100);
  endtask

  initial begin
    #(TCK * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int per, hi, exp;
    // R9: reset state
    #(TCK * 3);
    @(negedge clk);
    check(tk == '0, "R9 tick in reset", int'(tk), 0);
    check(ck == '0, "R9 wave in reset", int'(ck), 0);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < 8; v++) begin
      sel = 3'(VEC[v][0]);
      for (int d = 0; d < ND; d++) begin
        case (d)
          0:       exp = VEC[v][1];                 // R1
          1:       exp = VEC[v][1];                 // R4
          2:       exp = VEC[v][2];                 // R2
          3:       exp = VEC[v][3];                 // R3
          default: exp = 4 * ((VEC[v][0] % 4) + 1); // R5
        endcase
        measure(d, per, hi);
        case (d)
          0:       check(per == exp, "R1 period", per, exp);
          1:       check(per == exp, "R4 period", per, exp);
          2:       check(per == exp, "R2 period", per, exp);
          3:       check(per == exp, "R3 period", per, exp);
          default: check(per == exp, "R5 period", per, exp);
        endcase
        check(hi == exp / 2, "R7 high cycles", hi, exp / 2);
      end
    end

    // R6: tick width on shortest ratio
    sel = 3'd0;
    measure(0, per, hi);
    @(negedge clk);
    check(tk[0] == 1'b0, "R6 tick after tick", int'(tk[0]), 0);
    @(negedge clk);
    check(tk[0] == 1'b1, "R6 tick at ratio 2", int'(tk[0]), 1);

    // R7: falls on edge after tick
    sel = 3'd3;
    measure(0, per, hi);
    check(ck[0] == 1'b1, "R7 high at tick", int'(ck[0]), 1);
    @(negedge clk);
    check(ck[0] == 1'b0, "R7 low after tick", int'(ck[0]), 0);

    // R8: mid-period change
    sel = 3'd3;
    measure(0, per, hi);          // ratio 8 now active for next period
    per = 0;
    do begin
      @(negedge clk);
      per++;
      if (per == 3) sel = 3'd7;
    end while (!tk[0] && per < 100);
    check(per == 8, "R8 current period kept", per, 8);
    per = 0;
    do begin @(negedge clk); per++; end while (!tk[0] && per < 100);
    check(per == 16, "R8 next period new ratio", per, 16);

    // R9: reset mid-run, release with new code
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(tk == '0, "R9 tick on async reset", int'(tk), 0);
    check(ck == '0, "R9 wave on async reset", int'(ck), 0);
    sel = 3'd2;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    per = 0;
    do begin @(negedge clk); per++; end while (!tk[0] && per < 100);
    check(per == 6, "R9 first tick after release", per, 6);
    per = 0;
    do begin @(negedge clk); per++; end while (!tk[2] && per < 100);
    check(per == 6, "R9 gen B first tick", per + 6, 12);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule